// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

This block supervises a clock generator through a down-counting watchdog. Software programs a 5-bit time-out value and picks one of two time bases: a short unit or a long unit. Each kick strobe reloads the watchdog. If the kicks stop, the countdown runs out after the programmed number of units. The block then raises a status flag that holds until software clears it, and it can also assert a reset pulse.

A second trigger, a frequency-change event strobe, can produce the same reset pulse. Each of the two pulse sources has its own enable. The pulse has a fixed, parameterized length. A trigger that arrives while a pulse is active restarts the length count, so the pulse grows longer and never splits into two.

The number of clock cycles in each unit is a parameter, one for each time base. Defaults suit 150 ms and 2.5 s units at 50 MHz, and a bench can shrink them.

Top module: `wdog_rst_ctl`

## Requirements
- R1: After reset the status flag and the reset pulse are low, and the countdown stays idle until the first kick, so no time-out happens however long the block waits.
- R2: With the short unit (select = 0), a programmed value v makes the status flag rise exactly (v+1)·SHORT_CYC clock cycles after the edge that samples the kick.
- R3: With the long unit (select = 1), the same value v gives (v+1)·LONG_CYC cycles.
- R4: The status flag stays high until a clear strobe is sampled. It is low in the cycle after the clear. If expiry and clear occur on the same edge, expiry wins and the flag stays high.
- R5: A kick restarts a full interval from the current settings. A kick sampled on the same edge as an expiry suppresses that expiry.
- R6: After an expiry the countdown stops, and no further expiry happens until the next kick.
- R7: When the watchdog reset enable is 1, the reset pulse goes high together with the status flag and stays high for PULSE_LEN cycles. When the enable is 0, an expiry produces no pulse.
- R8: When the frequency-change reset enable is 1, a frequency-change strobe makes the reset pulse high from the next cycle for PULSE_LEN cycles. When the enable is 0, the strobe produces no pulse.
- R9: A trigger that arrives while a pulse is active keeps the pulse high until PULSE_LEN cycles after the latest trigger, as one continuous pulse.
- R10: Changes to the time-out value and the unit select take effect only at the next kick. A countdown already running keeps the settings it was loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timeout | input | TO_W | Time-out value v; the interval is v+1 units |
| cfg_long | input | 1 | Unit select: 0 short, 1 long |
| cfg_rst_on_to | input | 1 | Enable the reset pulse on expiry |
| cfg_rst_on_fc | input | 1 | Enable the reset pulse on a frequency change |
| kick | input | 1 | Reload strobe that restarts the countdown |
| freq_chg | input | 1 | Frequency-change event strobe |
| sts_clr | input | 1 | Clears the time-out status flag |
| sts_timeout | output | 1 | Sticky time-out status flag |
| rst_pulse | output | 1 | Reset pulse output |

## Verification
The hardest case to produce from the ports is a kick that lands on exactly the same edge as the expiry. The bench reaches it by counting cycles from a previous kick with the smallest time-out value. It then strobes the kick so that it is sampled on the computed expiry edge, and expects the flag to stay low for a further full interval. The case where clear and expiry coincide is timed the same way. The case where a change to the settings during a countdown is ignored is shown by reprogramming right after a kick and observing the old interval.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    UNIT_SHORT = 1'b0,
    UNIT_LONG  = 1'b1
  } unit_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int SHORT_CYC = 7_500_000,
  parameter int LONG_CYC  = 125_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  restart,
  input  unit_e unit_sel,
  output logic  tick
);
  localparam int MAXC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] LIM_S = PW'(SHORT_CYC - 1);
  localparam logic [PW-1:0] LIM_L = PW'(LONG_CYC - 1);

  logic [PW-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit = (unit_sel == UNIT_LONG) ? LIM_L : LIM_S;
    tick  = run && !restart && (pre_q == limit);
    pre_d = pre_q;
    if (restart)   pre_d = '0;
    else if (tick) pre_d = '0;
    else if (run)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
  parameter int TO_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kick,
  input  logic [TO_W-1:0] load_val,
  input  logic            tick,
  output logic            running,
  output logic            expire
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            run_q, run_d;

  always_comb begin
    expire = tick && run_q && !kick && (cnt_q == '0);
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (kick) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (tick && run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int SW = $clog2(PULSE_LEN + 1);
  localparam logic [SW-1:0] LEN = SW'(PULSE_LEN);

  logic [SW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (trig)              left_d = LEN;
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_rst_ctl.sv
module wdog_rst_ctl
  import wdog_pkg::*;
#(
  parameter int SHORT_CYC = 7_500_000,
  parameter int LONG_CYC  = 125_000_000,
  parameter int TO_W      = 5,
  parameter int PULSE_LEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] cfg_timeout,
  input  logic            cfg_long,
  input  logic            cfg_rst_on_to,
  input  logic            cfg_rst_on_fc,
  input  logic            kick,
  input  logic            freq_chg,
  input  logic            sts_clr,
  output logic            sts_timeout,
  output logic            rst_pulse
);
  unit_e unit_q, unit_d;
  logic  sts_q, sts_d;
  logic  tick, running, expire, trig;

  always_comb begin
    unit_d = unit_q;
    if (kick) unit_d = unit_e'(cfg_long);
    sts_d = sts_q;
    if (expire)       sts_d = 1'b1;
    else if (sts_clr) sts_d = 1'b0;
    trig = (expire && cfg_rst_on_to) || (freq_chg && cfg_rst_on_fc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q <= UNIT_SHORT;
      sts_q  <= 1'b0;
    end else begin
      unit_q <= unit_d;
      sts_q  <= sts_d;
    end
  end

  wdog_prescale #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(kick),
    .unit_sel(unit_q), .tick(tick)
  );

  wdog_down #(.TO_W(TO_W)) u_down (
    .clk(clk), .rst_n(rst_n), .kick(kick), .load_val(cfg_timeout),
    .tick(tick), .running(running), .expire(expire)
  );

  wdog_stretch #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst_n(rst_n), .trig(trig), .pulse(rst_pulse)
  );

  assign sts_timeout = sts_q;
endmodule

// File: rtl/wdog_rst_ctl_chk.sv
module wdog_rst_ctl_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_rst_on_to,
  input logic cfg_rst_on_fc,
  input logic kick,
  input logic freq_chg,
  input logic sts_clr,
  input logic sts_timeout,
  input logic rst_pulse,
  input logic running,
  input logic expire
);
  localparam int CW = $clog2(PULSE_LEN + 1) + 1;
  localparam logic [CW-1:0] SAT = CW'(PULSE_LEN);

  logic          any_trig;
  logic [CW-1:0] since_q;

  assign any_trig = (expire && cfg_rst_on_to) || (freq_chg && cfg_rst_on_fc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= SAT;
    else if (any_trig)       since_q <= '0;
    else if (since_q != SAT) since_q <= since_q + 1'b1;
  end

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sts_timeout && !sts_clr |=> sts_timeout); // R4
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr && !expire |=> !sts_timeout); // R4
  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    kick && !sts_timeout |=> !sts_timeout); // R5
  AST_STAYS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !kick |=> !running); // R6
  AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire && cfg_rst_on_to |=> rst_pulse); // R7
  AST_FC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg && cfg_rst_on_fc |=> rst_pulse); // R8
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pulse && !any_trig |=> !rst_pulse); // R7
  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (since_q < SAT)); // R9
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < SAT) |-> rst_pulse); // R9
endmodule

bind wdog_rst_ctl wdog_rst_ctl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rst_on_to(cfg_rst_on_to),
  .cfg_rst_on_fc(cfg_rst_on_fc), .kick(kick), .freq_chg(freq_chg),
  .sts_clr(sts_clr), .sts_timeout(sts_timeout), .rst_pulse(rst_pulse),
  .running(running), .expire(expire)
);

// File: tb/sim_wdog_rst_ctl.sv
module sim_wdog_rst_ctl;
  localparam int SH = 4;
  localparam int LG = 10;
  localparam int PL = 3;

  logic       clk, rst_n;
  logic [4:0] cfg_timeout;
  logic       cfg_long, cfg_rst_on_to, cfg_rst_on_fc;
  logic       kick, freq_chg, sts_clr;
  logic       sts_timeout, rst_pulse;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  int    q_cyc[$];
  bit    q_sts[$];
  bit    q_pls[$];
  string q_tag[$];

  wdog_rst_ctl #(.SHORT_CYC(SH), .LONG_CYC(LG), .TO_W(5), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_long(cfg_long),
    .cfg_rst_on_to(cfg_rst_on_to), .cfg_rst_on_fc(cfg_rst_on_fc),
    .kick(kick), .freq_chg(freq_chg), .sts_clr(sts_clr),
    .sts_timeout(sts_timeout), .rst_pulse(rst_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations at their cycle
  always @(negedge clk) begin
    while (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
      n_chk++;
      if (q_cyc[0] != cyc || sts_timeout !== q_sts[0] || rst_pulse !== q_pls[0]) begin
        n_bad++;
        $display("FAIL %s at cycle %0d (due %0d): sts=%b pulse=%b expected sts=%b pulse=%b",
                 q_tag[0], cyc, q_cyc[0], sts_timeout, rst_pulse, q_sts[0], q_pls[0]);
      end
      void'(q_cyc.pop_front()); void'(q_sts.pop_front());
      void'(q_pls.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic expect_at(input int c, input bit s, input bit p, input string tag);
    q_cyc.push_back(c); q_sts.push_back(s); q_pls.push_back(p); q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_cyc.size() != 0) @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_kick(output int k);
    kick = 1'b1; k = cyc + 1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic do_fc(output int f);
    freq_chg = 1'b1; f = cyc + 1;
    @(negedge clk); freq_chg = 1'b0;
  endtask

  task automatic do_clear(input string tag);
    int c;
    sts_clr = 1'b1; c = cyc + 1;
    expect_at(c, 1'b0, 1'b0, tag);
    @(negedge clk); sts_clr = 1'b0;
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, k2, e, f;
    rst_n = 1'b0; kick = 0; freq_chg = 0; sts_clr = 0;
    cfg_timeout = 5'd2; cfg_long = 0; cfg_rst_on_to = 1; cfg_rst_on_fc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and idle without a kick
    expect_at(cyc + 1, 0, 0, "R1 reset state");
    expect_at(cyc + 200, 0, 0, "R1 idle before first kick");
    drain();

    // R2 and R7: short unit, v=2 -> 12 cycles, pulse PL cycles
    do_kick(k); e = k + 3 * SH;
    expect_at(e - 1, 0, 0, "R2 not yet expired");
    expect_at(e, 1, 1, "R2 expiry short unit / R7 pulse start");
    expect_at(e + PL - 1, 1, 1, "R7 pulse last cycle");
    expect_at(e + PL, 1, 0, "R7 pulse ended");
    expect_at(e + PL + 40, 1, 0, "R4 sticky / R6 stopped");
    drain();
    do_clear("R4 clear");
    expect_at(cyc + 60, 0, 0, "R6 no re-expiry without kick");
    drain();

    // R3: long unit, v=1 -> 20 cycles, watchdog pulse disabled (R7)
    cfg_long = 1; cfg_timeout = 5'd1; cfg_rst_on_to = 0;
    do_kick(k); e = k + 2 * LG;
    expect_at(e - 1, 0, 0, "R3 not yet expired");
    expect_at(e, 1, 0, "R3 expiry long unit / R7 no pulse when disabled");
    expect_at(e + 1, 1, 0, "R7 still no pulse");
    drain();
    do_clear("R4 clear after R3");

    // R5: kick before expiry restarts the full interval
    cfg_long = 0; cfg_timeout = 5'd3;
    do_kick(k);
    wait_to(k + 9);
    do_kick(k2); e = k2 + 4 * SH;
    expect_at(k + 4 * SH, 0, 0, "R5 first interval cancelled");
    expect_at(e - 1, 0, 0, "R5 restarted interval running");
    expect_at(e, 1, 0, "R5 restarted interval expires");
    drain();
    do_clear("R4 clear after R5");

    // R5: kick on the expiry edge suppresses it
    cfg_timeout = 5'd0;
    do_kick(k);
    wait_to(k + SH - 1);
    do_kick(k2);
    expect_at(k + SH, 0, 0, "R5 coincident kick suppresses expiry");
    expect_at(k2 + SH - 1, 0, 0, "R5 reloaded interval running");
    expect_at(k2 + SH, 1, 0, "R5 reloaded interval expires");
    drain();
    do_clear("R4 clear after coincident kick");

    // R4: clear on the expiry edge loses to expiry
    do_kick(k);
    wait_to(k + SH - 1);
    sts_clr = 1'b1;
    expect_at(k + SH, 1, 0, "R4 expiry beats simultaneous clear");
    @(negedge clk); sts_clr = 1'b0;
    drain();
    do_clear("R4 clear after collision");

    // R10: config changes apply at the next kick only
    cfg_timeout = 5'd0; cfg_long = 0;
    do_kick(k);
    cfg_timeout = 5'd5; cfg_long = 1;
    expect_at(k + SH - 1, 0, 0, "R10 old settings running");
    expect_at(k + SH, 1, 0, "R10 old settings kept");
    drain();
    do_clear("R4 clear in R10");
    do_kick(k); e = k + 6 * LG;
    expect_at(e - 1, 0, 0, "R10 new settings running");
    expect_at(e, 1, 0, "R10 new settings at next kick");
    drain();
    do_clear("R4 clear after R10");

    // R8: frequency-change pulse enabled, then disabled
    cfg_rst_on_fc = 1;
    do_fc(f);
    expect_at(f, 0, 1, "R8 pulse starts");
    expect_at(f + PL - 1, 0, 1, "R8 pulse last cycle");
    expect_at(f + PL, 0, 0, "R8 pulse ended");
    drain();
    cfg_rst_on_fc = 0;
    do_fc(f);
    expect_at(f, 0, 0, "R8 no pulse when disabled");
    expect_at(f + 1, 0, 0, "R8 still no pulse");
    drain();

    // R9: retrigger extends the pulse
    cfg_rst_on_fc = 1;
    do_fc(f);
    wait_to(f + 1);
    do_fc(k2);
    expect_at(f + PL, 0, 1, "R9 pulse extended past first length");
    expect_at(k2 + PL - 1, 0, 1, "R9 extended last cycle");
    expect_at(k2 + PL, 0, 0, "R9 extended pulse ended");
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule